// File: doc/BRIEF.md
# Packed Halfword Multiply Accumulator

This block is a multiply-accumulate datapath built around one 40-bit signed accumulator. The upper eight bits act as guard bits, so long runs of 32-bit products can build up without losing their sign. Commands come in on a valid/ready port. Each command carries a 2-bit operation code, two 32-bit operands, a 3-bit accumulator selector and a condition-pass flag. There are four operations:

- a full 32x32 signed multiply-accumulate;
- a dual 16x16 signed multiply on packed halfwords, where both products go into the accumulator;
- a load of the accumulator from two words;
- a readback of the accumulator as two words.

A multiply-accumulate occupies the datapath for a fixed number of cycles, and `busy` shows this. Readback words leave on a valid/ready result port: the low word first, then the high word. The sender of commands holds `cmd_valid` and its fields steady until `cmd_ready` is seen at a rising edge. The block lowers `cmd_ready` while an accumulation is in flight and while a readback has words left to deliver. On the result port, `rsp_data` and `rsp_last` stay stable while `rsp_valid` is high and `rsp_ready` is low. A word counts as delivered on a rising edge where both are high.

Top module: `pair_mac40`

## Requirements
- R1: After synchronous active-high reset the accumulator holds zero, `cmd_ready` is high, and `busy`, `illegal` and `rsp_valid` are low.
- R2: Operation code 0 adds the signed 32x32 product of `cmd_a` and `cmd_b` to the accumulator, keeping only the low 40 bits of the sum (wrap modulo 2^40, no saturation).
- R3: Operation code 1 forms the signed products `cmd_a[15:0]*cmd_b[15:0]` and `cmd_a[31:16]*cmd_b[31:16]` and adds both to the accumulator, modulo 2^40.
- R4: Operation code 2 sets accumulator bits [31:0] to `cmd_a` and bits [39:32] to `cmd_b[7:0]`; bits [31:8] of `cmd_b` have no effect.
- R5: Operation code 3 returns accumulator bits [31:0] with `rsp_last`=0, then the high word with `rsp_last`=1. The high word is accumulator bits [39:32] sign-extended to 32 bits. The high word is valid in the cycle right after the low word is taken.
- R6: While `rsp_valid` is high and `rsp_ready` low, `rsp_data` and `rsp_last` hold. `cmd_ready` stays low from the acceptance of a readback until its high word is taken.
- R7: A command accepted with `cmd_cond`=0 changes nothing and produces no result words.
- R8: A command accepted with `cmd_sel` other than 0 changes nothing, produces no result words, and raises `illegal` for exactly the cycle after acceptance.
- R9: After a multiply-accumulate is accepted, `busy` is high and `cmd_ready` low for MAC_LAT-1 cycles. A readback accepted afterwards sees the updated value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command this cycle |
| cmd_op | input | 2 | 0 full MAC, 1 packed MAC, 2 load, 3 readback |
| cmd_sel | input | 3 | Accumulator selector; only 0 is legal |
| cmd_cond | input | 1 | Condition passed; 0 turns the command into a no-op |
| cmd_a | input | 32 | First operand / low load word |
| cmd_b | input | 32 | Second operand / high load word |
| busy | output | 1 | Multiply-accumulate in flight |
| illegal | output | 1 | One-cycle pulse after a command with a bad selector |
| rsp_valid | output | 1 | Result word present |
| rsp_ready | input | 1 | Consumer takes the result word |
| rsp_data | output | 32 | Result word |
| rsp_last | output | 1 | High (second) word of a readback |

## Verification
The bench aims at the accumulator's edges. It carries a sum from 0x7F_FFFFFFFF past the top, where a design that saturated or kept 64 bits would read back the wrong high word. It also drives the packed case of two -32768*-32768 products, which only fits because of the guard bits; a 32-bit accumulator would return a negative high word.

Loads are driven with junk in `cmd_b[31:8]` and with a negative byte, to catch a load that keeps too many bits or a readback that zero-extends. Readbacks run under random back-pressure, to catch a result port that drops or changes a word while stalled, or that lets a new command in mid-readback. Commands with a failed condition or a bad selector are followed by readbacks and checks of the `illegal` pulse, which expose a design that still updates or answers.

// File: rtl/pmac_pkg.sv
package pmac_pkg;

  typedef enum logic [1:0] {
    OP_MAC  = 2'd0,
    OP_PAIR = 2'd1,
    OP_LOAD = 2'd2,
    OP_READ = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_BUSY  = 2'd1,
    ST_RD_LO = 2'd2,
    ST_RD_HI = 2'd3
  } st_e;

endpackage

// File: rtl/pmac_mult.sv
module pmac_mult #(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 40,
  parameter int LANES  = 2
) (
  input  logic [WORD_W-1:0] op_a,
  input  logic [WORD_W-1:0] op_b,
  input  logic              packed_mode,
  output logic [ACC_W-1:0]  product
);
  localparam int LANE_W = WORD_W / LANES;

  logic signed [ACC_W-1:0] full_a, full_b, full_p;
  logic [ACC_W-1:0] lane_ext [LANES];
  logic [ACC_W-1:0] lane_sum;

  // full-width signed product, truncated to accumulator width
  assign full_a = {{(ACC_W-WORD_W){op_a[WORD_W-1]}}, op_a};
  assign full_b = {{(ACC_W-WORD_W){op_b[WORD_W-1]}}, op_b};
  assign full_p = full_a * full_b;

  // one signed product per packed lane
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic signed [ACC_W-1:0] la, lb;
    assign la = {{(ACC_W-LANE_W){op_a[g*LANE_W+LANE_W-1]}}, op_a[g*LANE_W +: LANE_W]};
    assign lb = {{(ACC_W-LANE_W){op_b[g*LANE_W+LANE_W-1]}}, op_b[g*LANE_W +: LANE_W]};
    assign lane_ext[g] = la * lb;
  end

  always_comb begin
    lane_sum = '0;
    for (int i = 0; i < LANES; i++) lane_sum = lane_sum + lane_ext[i];
  end

  assign product = packed_mode ? lane_sum : full_p;

endmodule

// File: rtl/pmac_acc.sv
module pmac_acc #(
  parameter int WORD_W = 32,
  parameter int ACC_W  = 40
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ld_en,
  input  logic [WORD_W-1:0]       ld_lo,
  input  logic [ACC_W-WORD_W-1:0] ld_guard,
  input  logic                    add_en,
  input  logic [ACC_W-1:0]        addend,
  output logic [ACC_W-1:0]        acc
);

  always_ff @(posedge clk) begin
    if (rst)         acc <= '0;
    else if (ld_en)  acc <= {ld_guard, ld_lo};
    else if (add_en) acc <= acc + addend;
  end

  // R1: accumulator is zero right after reset
  a_r1_reset_zero: assert property (@(posedge clk) $past(rst) |-> acc == '0);

  // R4: a load puts the low word and guard byte in place
  a_r4_load_place: assert property (@(posedge clk) disable iff (rst)
    ld_en |=> acc == {$past(ld_guard), $past(ld_lo)});

endmodule

// File: rtl/pmac_ctrl.sv
module pmac_ctrl import pmac_pkg::*; #(
  parameter int MAC_LAT = 3,
  parameter int SEL_W   = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [SEL_W-1:0] cmd_sel,
  input  logic             cmd_cond,
  input  logic             rsp_ready,
  output logic             cmd_ready,
  output logic             busy,
  output logic             illegal,
  output logic             rsp_valid,
  output logic             rsp_last,
  output logic             ld_en,
  output logic             cap_en,
  output logic             packed_mode,
  output logic             add_en
);
  localparam int CNT_W = $clog2(MAC_LAT + 1);

  st_e              st_q;
  logic [CNT_W-1:0] cnt_q;
  logic             illegal_q;
  op_e              op;
  logic             accept, legal, go;

  assign op          = op_e'(cmd_op);
  assign cmd_ready   = (st_q == ST_IDLE);
  assign accept      = cmd_valid && cmd_ready;
  assign legal       = (cmd_sel == '0);
  assign go          = accept && legal && cmd_cond;
  assign ld_en       = go && (op == OP_LOAD);
  assign cap_en      = go && (op == OP_MAC || op == OP_PAIR);
  assign packed_mode = (op == OP_PAIR);
  assign add_en      = (st_q == ST_BUSY) && (cnt_q == CNT_W'(1));
  assign busy        = (st_q == ST_BUSY);
  assign rsp_valid   = (st_q == ST_RD_LO) || (st_q == ST_RD_HI);
  assign rsp_last    = (st_q == ST_RD_HI);
  assign illegal     = illegal_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= ST_IDLE;
      cnt_q     <= '0;
      illegal_q <= 1'b0;
    end else begin
      illegal_q <= accept && !legal;
      case (st_q)
        ST_IDLE: begin
          if (cap_en) begin
            st_q  <= ST_BUSY;
            cnt_q <= CNT_W'(MAC_LAT - 1);
          end else if (go && op == OP_READ) begin
            st_q <= ST_RD_LO;
          end
        end
        ST_BUSY: begin
          if (add_en) st_q  <= ST_IDLE;
          else        cnt_q <= cnt_q - CNT_W'(1);
        end
        ST_RD_LO: if (rsp_ready) st_q <= ST_RD_HI;
        ST_RD_HI: if (rsp_ready) st_q <= ST_IDLE;
        default:  st_q <= ST_IDLE;
      endcase
    end
  end

  // R6: a stalled word keeps its position in the pair
  a_r6_stall_hold: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_last));

  // R5: the high word follows the low word in the next cycle
  a_r5_hi_next: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_last && rsp_ready |=> rsp_valid && rsp_last);

  // R8: an illegal pulse only follows an accepted bad selector
  a_r8_illegal_src: assert property (@(posedge clk) disable iff (rst)
    illegal |-> $past(cmd_valid && cmd_ready && cmd_sel != '0));

  // R9: busy only starts from an accepted arithmetic command
  a_r9_busy_src: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(cmd_valid && cmd_ready && cmd_cond && cmd_sel == '0 && !cmd_op[1]));

endmodule

// File: rtl/pair_mac40.sv
module pair_mac40 #(
  parameter int WORD_W  = 32,
  parameter int ACC_W   = 40,
  parameter int SEL_W   = 3,
  parameter int MAC_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic              cmd_cond,
  input  logic [WORD_W-1:0] cmd_a,
  input  logic [WORD_W-1:0] cmd_b,
  output logic              busy,
  output logic              illegal,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              rsp_last
);
  localparam int GUARD_W = ACC_W - WORD_W;

  logic             ld_en, cap_en, packed_mode, add_en;
  logic [ACC_W-1:0] product, prod_q, acc_q;

  pmac_ctrl #(.MAC_LAT(MAC_LAT), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_sel(cmd_sel), .cmd_cond(cmd_cond), .rsp_ready(rsp_ready),
    .cmd_ready(cmd_ready), .busy(busy), .illegal(illegal),
    .rsp_valid(rsp_valid), .rsp_last(rsp_last), .ld_en(ld_en),
    .cap_en(cap_en), .packed_mode(packed_mode), .add_en(add_en)
  );

  pmac_mult #(.WORD_W(WORD_W), .ACC_W(ACC_W), .LANES(2)) u_mult (
    .op_a(cmd_a), .op_b(cmd_b), .packed_mode(packed_mode), .product(product)
  );

  always_ff @(posedge clk) begin
    if (rst)         prod_q <= '0;
    else if (cap_en) prod_q <= product;
  end

  pmac_acc #(.WORD_W(WORD_W), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst(rst), .ld_en(ld_en), .ld_lo(cmd_a),
    .ld_guard(cmd_b[GUARD_W-1:0]), .add_en(add_en), .addend(prod_q), .acc(acc_q)
  );

  assign rsp_data = rsp_last ? {{(WORD_W-GUARD_W){acc_q[ACC_W-1]}}, acc_q[ACC_W-1:WORD_W]}
                             : acc_q[WORD_W-1:0];

  // R6: stalled data does not move
  a_r6_data_stable: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> $stable(rsp_data));

  // R7: a failed condition leaves the accumulator alone
  a_r7_cond_noop: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && !cmd_cond |=> $stable(acc_q));

  // R8: a bad selector leaves the accumulator alone
  a_r8_sel_noop: assert property (@(posedge clk) disable iff (rst)
    cmd_valid && cmd_ready && cmd_sel != '0 |=> $stable(acc_q));

  // R5: the high word is a sign extension of the guard byte
  a_r5_hi_sext: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_last |->
      rsp_data == {{(WORD_W-GUARD_W){rsp_data[GUARD_W-1]}}, rsp_data[GUARD_W-1:0]});

endmodule

// File: tb/sim_pair_mac40.sv
module sim_pair_mac40;
  localparam int LAT = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = '0;
  logic [2:0]  cmd_sel = '0;
  logic        cmd_cond = 1'b0;
  logic [31:0] cmd_a = '0, cmd_b = '0;
  logic        busy, illegal, rsp_valid, rsp_last;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_data;

  int checks = 0, fails = 0, cyc = 0;
  bit done = 0;
  bit stall_mode = 0;
  logic [39:0] model = '0;
  logic [32:0] expq [$];

  always #2.5 clk = ~clk;

  pair_mac40 #(.MAC_LAT(LAT)) u0 (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_sel(cmd_sel), .cmd_cond(cmd_cond), .cmd_a(cmd_a),
    .cmd_b(cmd_b), .busy(busy), .illegal(illegal), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_last(rsp_last)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  // driver: issue one command, update the model, queue expected words
  task automatic issue(input logic [1:0] op, input logic [2:0] sel, input logic cond,
                       input logic [31:0] a, input logic [31:0] b);
    logic signed [63:0] p;
    int h0, h1;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_sel = sel; cmd_cond = cond; cmd_a = a; cmd_b = b;
    while (!cmd_ready) @(negedge clk);
    @(posedge clk);
    #1 cmd_valid = 0;
    if (sel == 3'd0 && cond) begin
      case (op)
        2'd0: begin
          p = $signed({{32{a[31]}}, a}) * $signed({{32{b[31]}}, b});
          model = model + p[39:0];
        end
        2'd1: begin
          h0 = $signed(a[15:0]) * $signed(b[15:0]);
          h1 = $signed(a[31:16]) * $signed(b[31:16]);
          model = model + {{8{h0[31]}}, h0} + {{8{h1[31]}}, h1};
        end
        2'd2: model = {b[7:0], a};
        default: begin
          expq.push_back({1'b0, model[31:0]});
          expq.push_back({1'b1, {24{model[39]}}, model[39:32]});
        end
      endcase
    end
  endtask

  task automatic drain();
    while (expq.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // monitor: drives rsp_ready, pops and compares result words
  initial begin
    logic [32:0] e;
    bit lo_taken = 0;
    bit stalled = 0;
    logic [32:0] held = '0;
    forever begin
      @(negedge clk);
      rsp_ready = stall_mode ? ($urandom_range(0, 2) == 0) : 1'b1;
      #0.5;
      if (lo_taken) chk(rsp_valid && rsp_last, "R5 high word one cycle after low", {62'd0, rsp_valid, rsp_last}, 64'd3);
      if (stalled) chk(rsp_valid && {rsp_last, rsp_data} == held, "R6 stalled word held", {31'd0, rsp_last, rsp_data}, {31'd0, held});
      lo_taken = 0;
      stalled = 0;
      if (rsp_valid && !rsp_ready) begin stalled = 1; held = {rsp_last, rsp_data}; end
      if (rsp_valid && rsp_ready) begin
        if (expq.size() == 0) begin
          chk(0, "R7 unexpected result word", {31'd0, rsp_last, rsp_data}, 64'd0);
        end else begin
          e = expq.pop_front();
          chk({rsp_last, rsp_data} == e, e[32] ? "R5 high word" : "R5 low word",
              {31'd0, rsp_last, rsp_data}, {31'd0, e});
          if (!rsp_last) lo_taken = 1;
        end
      end
    end
  end

  // watchdog
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      summary();
    end
  end

  initial begin
    int n;
    repeat (3) @(posedge clk);
    #1 rst = 0;
    @(negedge clk);
    // R1: reset state
    chk(cmd_ready == 1, "R1 cmd_ready", {63'd0, cmd_ready}, 64'd1);
    chk(busy == 0, "R1 busy", {63'd0, busy}, 64'd0);
    chk(illegal == 0, "R1 illegal", {63'd0, illegal}, 64'd0);
    chk(rsp_valid == 0, "R1 rsp_valid", {63'd0, rsp_valid}, 64'd0);
    issue(2'd3, 0, 1, 0, 0);   // R1: zero readback
    drain();

    // R4: load with negative guard byte, then junk upper bits
    issue(2'd2, 0, 1, 32'h89AB_CDEF, 32'hFFFF_FF80);
    issue(2'd3, 0, 1, 0, 0);
    // R6: cmd_ready low while readback pending
    @(negedge clk);
    chk(cmd_ready == 0, "R6 cmd_ready low during readback", {63'd0, cmd_ready}, 64'd0);
    issue(2'd2, 0, 1, 32'h0000_1111, 32'h1234_5677);
    issue(2'd3, 0, 1, 0, 0);

    // R2: signed product
    issue(2'd2, 0, 1, 0, 0);
    issue(2'd0, 0, 1, 32'hFFFF_FFFD, 32'd7);
    // R9: busy window
    n = 0;
    @(negedge clk);
    while (busy) begin
      chk(cmd_ready == 0, "R9 cmd_ready low while busy", {63'd0, cmd_ready}, 64'd0);
      n++;
      @(negedge clk);
    end
    chk(n == LAT - 1, "R9 busy length", n, LAT - 1);
    issue(2'd3, 0, 1, 0, 0);
    issue(2'd0, 0, 1, 32'h7FFF_FFFF, 32'h7FFF_FFFF);
    issue(2'd3, 0, 1, 0, 0);
    // R2: wrap past top of 40 bits
    issue(2'd2, 0, 1, 32'hFFFF_FFFF, 32'h0000_007F);
    issue(2'd0, 0, 1, 32'd1, 32'd1);
    issue(2'd3, 0, 1, 0, 0);
    drain();

    // R3: packed halfwords
    issue(2'd2, 0, 1, 0, 0);
    issue(2'd1, 0, 1, 32'hFFFE_0003, 32'h0005_FFFC);
    issue(2'd3, 0, 1, 0, 0);
    issue(2'd2, 0, 1, 0, 0);
    issue(2'd1, 0, 1, 32'h8000_8000, 32'h8000_8000);
    issue(2'd3, 0, 1, 0, 0);
    drain();

    // R7: failed condition
    issue(2'd0, 0, 0, 32'd1000, 32'd1000);
    issue(2'd2, 0, 0, 32'h5555_5555, 32'h55);
    issue(2'd3, 0, 0, 0, 0);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid == 0, "R7 no result on failed condition", {63'd0, rsp_valid}, 64'd0);
    end
    issue(2'd3, 0, 1, 0, 0);
    drain();

    // R8: bad selector
    issue(2'd2, 3'd5, 1, 32'hDEAD_BEEF, 32'h12);
    @(negedge clk);
    chk(illegal == 1, "R8 illegal pulse", {63'd0, illegal}, 64'd1);
    @(negedge clk);
    chk(illegal == 0, "R8 illegal one cycle", {63'd0, illegal}, 64'd0);
    issue(2'd3, 3'd1, 1, 0, 0);
    repeat (3) begin
      @(negedge clk);
      chk(rsp_valid == 0, "R8 no result on bad selector", {63'd0, rsp_valid}, 64'd0);
    end
    issue(2'd3, 0, 1, 0, 0);
    drain();

    // R6: mixed traffic under back-pressure
    stall_mode = 1;
    for (int i = 0; i < 60; i++) begin
      issue(2'($urandom_range(0, 3)), ($urandom_range(0, 7) == 0) ? 3'd2 : 3'd0,
            ($urandom_range(0, 5) != 0), $urandom, $urandom);
      if (i % 5 == 4) issue(2'd3, 0, 1, 0, 0);
    end
    issue(2'd3, 0, 1, 0, 0);
    drain();
    stall_mode = 0;
    drain();

    done = 1;
    summary();
  end

endmodule